// File: doc/BRIEF.md
# Timer Output Compare Pulse Generator

This block is one timer channel that drives a single output pin from periodic compare events. A free-running counter counts undivided clock cycles from zero up to a programmable period and then wraps. Each wrap is a compare event. A 2-bit action field decides what the pin does at each event: it is held low, it gives a short high or low pulse of programmable width, or it toggles.

A pulse starts on the cycle after the compare event. It overlays the start of the next period and does not stretch it, so the event spacing stays exactly the programmed period. A counter enable gates the whole timer. While the enable is clear, software can select the action, the period and the width, and it can preset the toggle level through a load strobe. It then raises the enable to start compare operation.

Top module: `ocpg_top`

## Requirements
- R1: After reset the pin and the compare strobe are low, and the toggle level is 0.
- R2: While enabled with period P (P of 0 behaves as 1), the counter runs 0..P-1 and wraps. `cmp_evt_o` is high in the cycle where the count is P-1, which gives exactly one strobe every P cycles. The first strobe comes P-1 cycles after the enable rises.
- R3: Action code 0 holds the pin low whatever the events and width do.
- R4: Action code 1 rests low. After each event the pin is high for W cycles, where W is `pulse_width_i`, starting the cycle after the event.
- R5: Action code 2 rests high and drives a low pulse of W cycles, with the same timing as R4.
- R6: A width of 0 produces no pulse, so the pin stays at its rest level.
- R7: If W is P or more, each event restarts the pulse before it ends, so after the first event the pin stays at its active level without a gap.
- R8: Action code 3 inverts the pin at each event, effective the cycle after the event, and ignores the width.
- R9: A load strobe while disabled sets the toggle level to `preset_val_i` on the next cycle. A load strobe while enabled is ignored.
- R10: Clearing the enable stops events at once and returns the pin to the rest level of its action in the same cycle. For action 3 the rest level is the current toggle level. The count restarts from 0 on re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the pulse width time base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Counter enable |
| period_i | input | CNT_W | Compare period in cycles |
| oc_type_i | input | 2 | Output action: 0 low, 1 high pulse, 2 low pulse, 3 toggle |
| pulse_width_i | input | PW_W | Pulse width in cycles |
| preset_load_i | input | 1 | Loads the toggle level while disabled |
| preset_val_i | input | 1 | Toggle level to load |
| pin_o | output | 1 | Compare output pin |
| cmp_evt_o | output | 1 | One-cycle compare strobe |

## Verification
A corrupt count shows up on `cmp_evt_o` at the next wrap, within one period. Every pin waveform depends on the same count, so the pin shifts with it. A wrong pulse counter shows as a pulse that is one or more cycles too long or too short at the first event after enable. A wrong toggle level or a wrong preset path shows as an inverted pin in action 3 from the very first cycle of enable. The sweep compares every cycle against closed-form expectations over small periods and widths, so each of these faults appears within a few cycles of the run it affects.

// File: rtl/ocpg_pkg.sv
package ocpg_pkg;
  typedef enum logic [1:0] {
    OC_FORCE_LOW = 2'd0,
    OC_PULSE_HI  = 2'd1,
    OC_PULSE_LO  = 2'd2,
    OC_TOGGLE    = 2'd3
  } oc_type_e;
endpackage

// File: rtl/ocpg_counter.sv
module ocpg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             last;

  // period 0 acts as period 1
  assign limit = (period_i == '0) ? '0 : period_i - 1'b1;
  assign last  = (cnt_q >= limit);
  assign evt_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (last)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> cnt_q == '0);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !evt_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/ocpg_pulse_gen.sv
module ocpg_pulse_gen #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            evt_i,
  input  logic [PW_W-1:0] width_i,
  output logic            active_o
);
  logic [PW_W-1:0] pcnt_q;

  assign active_o = en_i && (pcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (!en_i)           pcnt_q <= '0;
    else if (evt_i)           pcnt_q <= width_i;   // restart, overlays next period
    else if (pcnt_q != '0)    pcnt_q <= pcnt_q - 1'b1;
  end

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i) |=> pcnt_q == $past(width_i));
  p_zero_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && width_i == '0) |=> !active_o || !en_i);
  p_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pcnt_q == '0);
endmodule

// File: rtl/ocpg_wave.sv
module ocpg_wave
  import ocpg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     evt_i,
  input  oc_type_e type_i,
  input  logic     active_i,
  input  logic     preset_load_i,
  input  logic     preset_val_i,
  output logic     pin_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             tog_q <= 1'b0;
    else if (!en_i && preset_load_i)         tog_q <= preset_val_i;
    else if (evt_i && type_i == OC_TOGGLE)   tog_q <= ~tog_q;
  end

  always_comb begin
    unique case (type_i)
      OC_FORCE_LOW: pin_o = 1'b0;
      OC_PULSE_HI:  pin_o = active_i;
      OC_PULSE_LO:  pin_o = ~active_i;
      OC_TOGGLE:    pin_o = tog_q;
      default:      pin_o = 1'b0;
    endcase
  end

  p_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && type_i == OC_TOGGLE) |=> tog_q != $past(tog_q));
  p_preset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && preset_load_i) |=> tog_q == $past(preset_val_i));
  p_preset_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !evt_i) |=> $stable(tog_q));
endmodule

// File: rtl/ocpg_top.sv
module ocpg_top
  import ocpg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PW_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [1:0]       oc_type_i,
  input  logic [PW_W-1:0]  pulse_width_i,
  input  logic             preset_load_i,
  input  logic             preset_val_i,
  output logic             pin_o,
  output logic             cmp_evt_o
);
  logic     evt;
  logic     active;
  oc_type_e oc_type;

  assign oc_type   = oc_type_e'(oc_type_i);
  assign cmp_evt_o = evt;

  ocpg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .period_i (period_i),
    .evt_o    (evt)
  );

  ocpg_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .evt_i    (evt),
    .width_i  (pulse_width_i),
    .active_o (active)
  );

  ocpg_wave u_wave (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (enable_i),
    .evt_i         (evt),
    .type_i        (oc_type),
    .active_i      (active),
    .preset_load_i (preset_load_i),
    .preset_val_i  (preset_val_i),
    .pin_o         (pin_o)
  );

  p_force_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_type == OC_FORCE_LOW |-> !pin_o);
  p_rest_hi_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && oc_type == OC_PULSE_HI) |-> !pin_o && !cmp_evt_o);
  p_rest_lo_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && oc_type == OC_PULSE_LO) |-> pin_o);
endmodule

// File: tb/tb_ocpg_top.sv
module tb_ocpg_top;
  localparam int CNT_W = 16;
  localparam int PW_W  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [1:0]       oc_type_i = '0;
  logic [PW_W-1:0]  pulse_width_i = '0;
  logic             preset_load_i = 1'b0;
  logic             preset_val_i = 1'b0;
  logic             pin_o;
  logic             cmp_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ocpg_top #(.CNT_W(CNT_W), .PW_W(PW_W)) dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic exp_pin(int ty, int p, int w, logic pre, int t);
    logic act;
    act = (t >= p) && ((t % p) + 1 <= w);
    case (ty)
      0: return 1'b0;
      1: return act;
      2: return ~act;
      default: return pre ^ logic'((t / p) & 1);
    endcase
  endfunction

  function automatic string req_of(int ty, int p, int w);
    if (ty == 0) return "R3";
    if (ty == 3) return "R8";
    if (w == 0)  return "R6";
    if (w >= p)  return "R7";
    return (ty == 1) ? "R4" : "R5";
  endfunction

  task automatic run_cfg(int ty, int pset, int w, logic pre);
    int p;
    int n;
    p = (pset == 0) ? 1 : pset;
    n = 3 * p + 10;
    @(negedge clk_i);
    enable_i = 1'b0;
    oc_type_i = 2'(ty);
    period_i = CNT_W'(pset);
    pulse_width_i = PW_W'(w);
    preset_load_i = 1'b1;
    preset_val_i = pre;
    @(negedge clk_i);
    preset_load_i = 1'b0;
    #1;
    if (ty == 3) chk("R9", pin_o, pre);
    @(negedge clk_i);
    enable_i = 1'b1;
    for (int t = 0; t < n; t++) begin
      #1;
      chk(req_of(ty, p, w), pin_o, exp_pin(ty, p, w, pre, t));
      chk("R2", cmp_evt_o, (t % p) == p - 1);
      @(negedge clk_i);
      // load strobe while enabled must be ignored (R9)
      preset_load_i = (t == 0);
      preset_val_i = ~pre;
    end
    enable_i = 1'b0;
    preset_load_i = 1'b0;
    #1;
    chk("R10", cmp_evt_o, 1'b0);
    chk("R10", pin_o, (ty == 2) ? 1'b1 : (ty == 3) ? exp_pin(ty, p, w, pre, n) : 1'b0);
  endtask

  initial begin
    #1;
    chk("R1", pin_o, 1'b0);
    chk("R1", cmp_evt_o, 1'b0);
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R1", pin_o, 1'b0);
    chk("R1", cmp_evt_o, 1'b0);
    oc_type_i = 2'd3;
    #1;
    chk("R1", pin_o, 1'b0);
    for (int ty = 0; ty < 4; ty++)
      for (int ps = 0; ps <= 6; ps++)
        for (int wi = 0; wi < 7; wi++)
          for (int pr = 0; pr < ((ty == 3) ? 2 : 1); pr++) begin
            int w;
            w = (wi == 6) ? 255 : (wi == 5) ? 7 : wi;
            run_cfg(ty, ps, w, logic'(pr));
          end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule